// File: doc/BRIEF.md
# Register Bit-Field Read-Modify-Write Engine

This block lets a host processor change a bit field inside a register of a serial peripheral with one write, and then get a conditioned conversion reading back with one read. The host writes one 32-bit command word. The top byte is the opcode, the next byte is the peripheral register address, the third byte is a field mask, and the low byte is a right-aligned payload. The host can therefore keep a fixed constant per field and add the new value to it. For example, 0x22143800 + 2 gives 0x22143802.

For opcode 0x22 the engine runs four steps in order:

1. It reads the addressed byte over a byte-oriented request/acknowledge transaction port.
2. It shifts the payload up to the lowest set mask bit and merges it under the mask.
3. It writes the merged byte back.
4. It requests a conversion.

The raw reading is then sign-extended, multiplied by a host-set scale, shifted right by eight with sign, and offset. The result goes into a readback register. A busy flag covers the whole run. An error flag records commands that were rejected.

A serial master such as an SPI master attaches to the transaction port. The peripheral latency sets how long the run takes. With an immediately acknowledging transport the result is ready four cycles after the command is accepted, well before a following host read.

Top module: `field_rmw_engine`

## Requirements
- R1: After reset the following hold: busy is 0, the error flag is 0, and no transaction request is raised. The host reads give readback 0, scale 0x100 (sign-extended to 32 bits) and offset 0.
- R2: A command of opcode 0x22 raises three requests in this order: kind 0 (register read), kind 1 (register write) and kind 2 (conversion). The read and the write carry address bits [23:16]. Each request holds its kind, address and data steady until it is acknowledged.
- R3: The byte written back equals (read & ~mask) | ((payload << k) & mask), where k is the index of the lowest set bit of mask bits [15:8] and payload is bits [7:0]. A zero mask writes back the byte exactly as it was read.
- R4: The readback becomes ((sext(raw) * scale) >>> 8) + offset, modulo 2^32. Here raw is the 12-bit two's complement conversion value, scale is the signed 16-bit value at host address 1, and offset is the 32-bit value at host address 2.
- R5: Busy rises on the clock edge that accepts a command. It falls on the edge that writes the readback, which is one cycle after the conversion acknowledge. With a peripheral that acknowledges at once, busy falls on the 4th edge after acceptance.
- R6: A command whose opcode is not 0x22, written while the engine is idle, starts no transaction and sets the error flag. An accepted command clears the error flag.
- R7: A command written while a run is in progress, other than in its final cycle, is dropped and sets the error flag. The run in progress completes unchanged.
- R8: A command written in the final cycle of a run is accepted in that cycle. On the same edge the readback takes the finished result and the new run starts, so busy stays high.
- R9: A host read at address 0 returns the readback and at address 1 the scale sign-extended to 32 bits. Address 2 returns the offset. Address 3 returns the error flag in bit 1 and busy in bit 0, with the other bits zero. A host write to address 0 is a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Host register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from host_addr |
| busy | output | 1 | Run in progress |
| err | output | 1 | Last command was rejected |
| xfer_req | output | 1 | Transaction request, held until acknowledged |
| xfer_kind | output | 2 | 0 register read, 1 register write, 2 conversion |
| xfer_addr | output | 8 | Peripheral register address |
| xfer_wdata | output | 8 | Byte to write for kind 1 |
| xfer_ack | input | 1 | One-cycle transaction acknowledge |
| xfer_rdata | input | 12 | Read byte (low 8 bits) or raw conversion value, valid with the acknowledge |

## Verification
Two things can happen on the same edge. The readback update that ends one run can coincide with the acceptance of the next command. The bench provokes this by watching for the edge that consumes the conversion acknowledge and placing a command write in the very next cycle.

A reference model in the bench tracks busy, the error flag and the expected readback edge by edge. It is compared with the outputs after every clock. On the collision edge the model expects two things together: busy stays high, and the readback holds the first run's conditioned value. It then expects the second run to write its own merged byte and produce its own result. Writes one cycle earlier, during the run, are checked separately as rejections.

// File: rtl/rmw_pkg.sv
// Shared constants and types for the bit-field read-modify-write engine.
// Assumes byte-wide peripheral registers and an 8-bit opcode/address/mask/payload split.
package rmw_pkg;
    localparam int          CMD_W        = 32;
    localparam int          BYTE_W       = 8;
    localparam int          HOST_ADDR_W  = 2;
    localparam logic [7:0]  OP_FIELD_RMW = 8'h22;

    localparam logic [HOST_ADDR_W-1:0] HA_RESULT = 2'd0;
    localparam logic [HOST_ADDR_W-1:0] HA_SCALE  = 2'd1;
    localparam logic [HOST_ADDR_W-1:0] HA_OFFSET = 2'd2;
    localparam logic [HOST_ADDR_W-1:0] HA_STATUS = 2'd3;

    typedef enum logic [1:0] {
        XK_READ    = 2'd0,
        XK_WRITE   = 2'd1,
        XK_CONVERT = 2'd2
    } xfer_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_READ,
        SQ_WRITE,
        SQ_CONV,
        SQ_FINISH
    } seq_state_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic [7:0] addr;
        logic [7:0] mask;
        logic [7:0] payload;
    } cmd_t;
endpackage

// File: rtl/rmw_field_merge.sv
// Field merge: aligns a right-justified payload to the lowest set bit of the
// mask, confines it to the mask and replaces those bits of the read value.
// Assumes a purely combinational use; a zero mask returns the read value.
module rmw_field_merge #(
    parameter int W    = 8,
    localparam int SH_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] payload,
    output logic [W-1:0] merged
);
    logic [SH_W-1:0] low_idx;
    logic [W-1:0]    placed;

    // Priority encoder: scan downward so the lowest set mask bit wins.
    always_comb begin
        low_idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask[i]) low_idx = SH_W'(i);
        end
    end

    // Shift the payload into place and merge it under the mask.
    always_comb begin
        placed = (payload << low_idx) & mask;
        merged = (old_val & ~mask) | placed;
    end
endmodule

// File: rtl/rmw_condition.sv
// Conditioning datapath: sign-extends a raw reading, multiplies by a signed
// scale, shifts right arithmetically by FRAC_BITS and adds a signed offset.
// Assumes RES_W is wide enough for the result; it wraps modulo 2^RES_W.
module rmw_condition #(
    parameter int RAW_W     = 12,
    parameter int SCALE_W   = 16,
    parameter int FRAC_BITS = 8,
    parameter int RES_W     = 32,
    localparam int PROD_W   = RAW_W + SCALE_W
) (
    input  logic [RAW_W-1:0]   raw,
    input  logic [SCALE_W-1:0] scale,
    input  logic [RES_W-1:0]   offset,
    output logic [RES_W-1:0]   result
);
    logic signed [RAW_W-1:0]   raw_s;
    logic signed [SCALE_W-1:0] scale_s;
    logic signed [PROD_W-1:0]  product;
    logic signed [PROD_W-1:0]  shifted;
    logic        [RES_W-1:0]   widened;

    // Signed multiply with operands sign-extended to product width.
    always_comb begin
        raw_s   = raw;
        scale_s = scale;
        product = PROD_W'(raw_s) * PROD_W'(scale_s);
        shifted = product >>> FRAC_BITS;
    end

    // Bring the scaled value to result width, sign-extending or truncating.
    generate
        if (PROD_W < RES_W) begin : g_extend
            assign widened = {{(RES_W - PROD_W){shifted[PROD_W-1]}}, shifted};
        end else begin : g_trunc
            assign widened = shifted[RES_W-1:0];
        end
    endgenerate

    // Add the offset; wraparound is intended.
    always_comb result = widened + offset;
endmodule

// File: rtl/rmw_sequencer.sv
// Command sequencer: accepts a command word, then steps through register read,
// register write and conversion requests on a request/acknowledge port.
// Assumes the acknowledge lasts one cycle and carries read data with it.
// A command is accepted while idle or in the final (finish) cycle of a run.
module rmw_sequencer
    import rmw_pkg::*;
#(
    parameter int RAW_W = 12,
    parameter int RD_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              xfer_ack,
    input  logic [RD_W-1:0]   xfer_rdata,
    output logic              busy,
    output logic              err,
    output logic              xfer_req,
    output xfer_kind_e        xfer_kind,
    output logic [BYTE_W-1:0] xfer_addr,
    output logic [BYTE_W-1:0] old_byte,
    output logic [BYTE_W-1:0] fld_mask,
    output logic [BYTE_W-1:0] fld_payload,
    output logic [RAW_W-1:0]  raw,
    output logic              finish
);
    seq_state_e state_q, state_d;
    cmd_t       cmd_in;
    cmd_t       cmd_q;
    logic       can_accept;
    logic       start;

    // Decode the incoming command and decide whether it can be taken now.
    always_comb begin
        cmd_in     = cmd_t'(cmd_word);
        finish     = (state_q == SQ_FINISH);
        can_accept = cmd_wr && ((state_q == SQ_IDLE) || finish);
        start      = can_accept && (cmd_in.opcode == OP_FIELD_RMW);
    end

    // Next-state logic for the read, write, convert, finish sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:   if (start)    state_d = SQ_READ;
            SQ_READ:   if (xfer_ack) state_d = SQ_WRITE;
            SQ_WRITE:  if (xfer_ack) state_d = SQ_CONV;
            SQ_CONV:   if (xfer_ack) state_d = SQ_FINISH;
            SQ_FINISH: state_d = start ? SQ_READ : SQ_IDLE;
            default:   state_d = SQ_IDLE;
        endcase
    end

    // State register and command capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cmd_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start) cmd_q <= cmd_in;
        end
    end

    // Capture the byte read back and the raw conversion value on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            old_byte <= '0;
            raw      <= '0;
        end else if (xfer_ack) begin
            if (state_q == SQ_READ) old_byte <= xfer_rdata[BYTE_W-1:0];
            if (state_q == SQ_CONV) raw      <= xfer_rdata[RAW_W-1:0];
        end
    end

    // Error flag: set by a rejected command, cleared by an accepted one.
    always_ff @(posedge clk) begin
        if (!rst_n)         err <= 1'b0;
        else if (cmd_wr)    err <= !start;
    end

    // Request outputs follow the state register.
    always_comb begin
        busy        = (state_q != SQ_IDLE);
        xfer_req    = (state_q == SQ_READ) || (state_q == SQ_WRITE) || (state_q == SQ_CONV);
        xfer_kind   = (state_q == SQ_WRITE) ? XK_WRITE :
                      (state_q == SQ_CONV)  ? XK_CONVERT : XK_READ;
        xfer_addr   = cmd_q.addr;
        fld_mask    = cmd_q.mask;
        fld_payload = cmd_q.payload;
    end
endmodule

// File: rtl/field_rmw_engine.sv
// Top of the bit-field read-modify-write engine: host register port, scale and
// offset registers, readback register, and the sequencer/merge/condition parts.
// Assumes host reads are combinational on host_addr and writes take one cycle.
module field_rmw_engine
    import rmw_pkg::*;
#(
    parameter int RAW_W     = 12,
    parameter int SCALE_W   = 16,
    parameter int FRAC_BITS = 8,
    parameter int RES_W     = 32,
    localparam int RD_W     = (RAW_W > BYTE_W) ? RAW_W : BYTE_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_we,
    input  logic [HOST_ADDR_W-1:0] host_addr,
    input  logic [CMD_W-1:0]       host_wdata,
    output logic [CMD_W-1:0]       host_rdata,
    output logic                   busy,
    output logic                   err,
    output logic                   xfer_req,
    output logic [1:0]             xfer_kind,
    output logic [BYTE_W-1:0]      xfer_addr,
    output logic [BYTE_W-1:0]      xfer_wdata,
    input  logic                   xfer_ack,
    input  logic [RD_W-1:0]        xfer_rdata
);
    localparam logic [SCALE_W-1:0] SCALE_UNITY = SCALE_W'(1) << FRAC_BITS;

    logic               cmd_wr;
    logic               seq_finish;
    xfer_kind_e         kind_e;
    logic [BYTE_W-1:0]  old_byte;
    logic [BYTE_W-1:0]  fld_mask;
    logic [BYTE_W-1:0]  fld_payload;
    logic [RAW_W-1:0]   raw;
    logic [SCALE_W-1:0] scale_q;
    logic [RES_W-1:0]   offset_q;
    logic [RES_W-1:0]   cond_val;
    logic [RES_W-1:0]   result_q;

    // Host write to the command address.
    always_comb cmd_wr = host_we && (host_addr == HA_RESULT);

    rmw_sequencer #(
        .RAW_W (RAW_W),
        .RD_W  (RD_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .cmd_word    (host_wdata),
        .xfer_ack    (xfer_ack),
        .xfer_rdata  (xfer_rdata),
        .busy        (busy),
        .err         (err),
        .xfer_req    (xfer_req),
        .xfer_kind   (kind_e),
        .xfer_addr   (xfer_addr),
        .old_byte    (old_byte),
        .fld_mask    (fld_mask),
        .fld_payload (fld_payload),
        .raw         (raw),
        .finish      (seq_finish)
    );

    rmw_field_merge #(
        .W (BYTE_W)
    ) u_merge (
        .old_val (old_byte),
        .mask    (fld_mask),
        .payload (fld_payload),
        .merged  (xfer_wdata)
    );

    rmw_condition #(
        .RAW_W     (RAW_W),
        .SCALE_W   (SCALE_W),
        .FRAC_BITS (FRAC_BITS),
        .RES_W     (RES_W)
    ) u_cond (
        .raw    (raw),
        .scale  (scale_q),
        .offset (offset_q),
        .result (cond_val)
    );

    // Present the transaction kind as a plain two-bit code.
    always_comb xfer_kind = kind_e;

    // Scale and offset registers written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scale_q  <= SCALE_UNITY;
            offset_q <= '0;
        end else if (host_we) begin
            if (host_addr == HA_SCALE)  scale_q  <= host_wdata[SCALE_W-1:0];
            if (host_addr == HA_OFFSET) offset_q <= host_wdata[RES_W-1:0];
        end
    end

    // Readback register loads the conditioned value in the finish cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)          result_q <= '0;
        else if (seq_finish) result_q <= cond_val;
    end

    // Host read multiplexer.
    always_comb begin
        unique case (host_addr)
            HA_RESULT: host_rdata = CMD_W'(result_q);
            HA_SCALE:  host_rdata = {{(CMD_W - SCALE_W){scale_q[SCALE_W-1]}}, scale_q};
            HA_OFFSET: host_rdata = CMD_W'(offset_q);
            HA_STATUS: host_rdata = {{(CMD_W - 2){1'b0}}, err, busy};
            default:   host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/field_rmw_engine_chk.sv
// Checker for field_rmw_engine: request ordering and hold, busy timing,
// command rejection and acceptance rules. Bound to the top below.
module field_rmw_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_we,
    input logic [1:0]  host_addr,
    input logic [31:0] host_wdata,
    input logic        busy,
    input logic        err,
    input logic        xfer_req,
    input logic [1:0]  xfer_kind,
    input logic [7:0]  xfer_addr,
    input logic        xfer_ack,
    input logic        seq_finish
);
    logic was_rst;
    logic cmd_wr;

    // Remember whether the previous edge was a reset edge.
    always_ff @(posedge clk) was_rst <= !rst_n;

    // Command write seen at the host port.
    always_comb cmd_wr = host_we && (host_addr == 2'd0);

    // R1
    always @(negedge clk) begin
        if (was_rst === 1'b1) begin
            rst_state_chk: assert (!busy && !err && !xfer_req);
        end
    end

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_kind) && $stable(xfer_addr));

    // R2
    read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && xfer_ack && xfer_kind == 2'd0 |=> xfer_req && xfer_kind == 2'd1);

    // R2
    write_then_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && xfer_ack && xfer_kind == 2'd1 |=> xfer_req && xfer_kind == 2'd2);

    // R5
    idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !xfer_req);

    // R5
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(xfer_req && xfer_ack && xfer_kind == 2'd2, 2));

    // R6
    bad_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && !busy && host_wdata[31:24] != 8'h22 |=> err && !busy);

    // R7
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && busy && !seq_finish |=> err);

    // R8
    finish_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && seq_finish && host_wdata[31:24] == 8'h22 |=> busy && xfer_req && !err);
endmodule

bind field_rmw_engine field_rmw_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .busy       (busy),
    .err        (err),
    .xfer_req   (xfer_req),
    .xfer_kind  (xfer_kind),
    .xfer_addr  (xfer_addr),
    .xfer_ack   (xfer_ack),
    .seq_finish (seq_finish)
);

// File: tb/test_field_rmw_engine.sv
// Bench for field_rmw_engine: behavioural peripheral, edge-by-edge reference
// model of busy/error/readback, and directed checks per requirement.
module test_field_rmw_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        busy, err, xfer_req;
    logic [1:0]  xfer_kind;
    logic [7:0]  xfer_addr, xfer_wdata;
    logic        xfer_ack = 1'b0;
    logic [11:0] xfer_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;

    // Behavioural peripheral state
    logic [7:0]  periph [256];
    logic [11:0] conv_val = '0;
    int          lat = 0;
    int          wait_cnt = 0;
    int          kind_log[$];
    int          addr_log[$];

    // Reference model state
    logic        m_busy = 1'b0, m_err = 1'b0, m_fin = 1'b0;
    logic [11:0] m_raw = '0;
    logic [15:0] m_scale = 16'h0100;
    logic [31:0] m_offset = '0, m_result = '0;

    field_rmw_engine i_field_rmw_engine (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy), .err(err),
        .xfer_req(xfer_req), .xfer_kind(xfer_kind), .xfer_addr(xfer_addr),
        .xfer_wdata(xfer_wdata), .xfer_ack(xfer_ack), .xfer_rdata(xfer_rdata)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] merge_ref(logic [7:0] old, logic [7:0] mask, logic [7:0] pay);
        int k = 0;
        for (int i = 0; i < 8; i++) begin
            if (mask[i]) begin k = i; break; end
        end
        return (old & ~mask) | (8'(pay << k) & mask);
    endfunction

    function automatic logic [31:0] cond_ref(logic [11:0] raw, logic [15:0] sc, logic [31:0] off);
        longint r = longint'($signed(raw));
        longint s = longint'($signed(sc));
        longint p = (r * s) >>> 8;
        return 32'(p + longint'($signed(off)));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Peripheral: acknowledges after lat waiting cycles, one-cycle ack.
    always @(negedge clk) begin
        if (xfer_req && wait_cnt >= lat) begin
            xfer_ack <= 1'b1;
            wait_cnt <= 0;
            kind_log.push_back(int'(xfer_kind));
            addr_log.push_back(int'(xfer_addr));
            case (xfer_kind)
                2'd0: xfer_rdata <= {4'h0, periph[xfer_addr]};
                2'd1: periph[xfer_addr] = xfer_wdata;
                default: xfer_rdata <= conv_val;
            endcase
        end else begin
            xfer_ack <= 1'b0;
            if (xfer_req) wait_cnt <= wait_cnt + 1;
        end
    end

    // Reference model, advanced on every edge and compared just after it (R5, R6, R7, R8).
    always @(posedge clk) begin
        logic done_now;
        if (!rst_n) begin
            m_busy = 0; m_err = 0; m_fin = 0; m_raw = '0;
            m_scale = 16'h0100; m_offset = '0; m_result = '0;
        end else begin
            done_now = m_fin;
            m_fin = 0;
            if (done_now) begin
                m_result = cond_ref(m_raw, m_scale, m_offset);
                m_busy = 0;
            end
            if (host_we && host_addr == 2'd0) begin
                if (m_busy) m_err = 1;
                else if (host_wdata[31:24] == 8'h22) begin m_busy = 1; m_err = 0; end
                else m_err = 1;
            end
            if (host_we && host_addr == 2'd1) m_scale = host_wdata[15:0];
            if (host_we && host_addr == 2'd2) m_offset = host_wdata;
            if (xfer_req && xfer_ack && xfer_kind == 2'd2) begin
                m_raw = xfer_rdata;
                m_fin = 1;
            end
            #2;
            check("R5 busy per-cycle", {31'b0, busy}, {31'b0, m_busy});
            check("R6/R7 err per-cycle", {31'b0, err}, {31'b0, m_err});
        end
    end

    task automatic host_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        host_we <= 1'b1; host_addr <= a; host_wdata <= d;
        @(negedge clk);
        host_we <= 1'b0;
    endtask

    task automatic host_read(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin
            @(posedge clk); #3; n++;
        end while (busy && n < 200);
    endtask

    // Run one command and check the write-back byte, request order and readback.
    task automatic run_rmw(string req, logic [31:0] cmd, logic [7:0] init, logic [11:0] cv);
        logic [31:0] rb;
        logic [7:0]  a = cmd[23:16];
        logic [7:0]  exp_b = merge_ref(init, cmd[15:8], cmd[7:0]);
        periph[a] = init;
        conv_val = cv;
        kind_log.delete(); addr_log.delete();
        host_write(2'd0, cmd);
        wait_idle();
        check({req, " R3 write-back byte"}, {24'b0, periph[a]}, {24'b0, exp_b});
        check("R2 request count", kind_log.size(), 3);
        if (kind_log.size() == 3) begin
            check("R2 order read",    kind_log[0], 0);
            check("R2 order write",   kind_log[1], 1);
            check("R2 order convert", kind_log[2], 2);
            check("R2 read address",  addr_log[0], {24'b0, a});
            check("R2 write address", addr_log[1], {24'b0, a});
        end
        host_read(2'd0, rb);
        check({req, " R4 readback"}, rb, cond_ref(cv, m_scale, m_offset));
    endtask

    initial begin
        #(20 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int n;
        for (int i = 0; i < 256; i++) periph[i] = 8'(i ^ 8'h3C);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #3;
        // R1 reset state
        check("R1 busy", {31'b0, busy}, 0);
        check("R1 err", {31'b0, err}, 0);
        check("R1 xfer_req", {31'b0, xfer_req}, 0);
        host_read(2'd0, rd); check("R1 R9 readback", rd, 32'h0);
        host_read(2'd1, rd); check("R1 R9 scale", rd, 32'h0000_0100);
        host_read(2'd2, rd); check("R1 R9 offset", rd, 32'h0);
        host_read(2'd3, rd); check("R1 R9 status", rd, 32'h0);

        // R5 timing with an immediate peripheral
        lat = 0;
        periph[8'h14] = 8'hC5;
        conv_val = 12'h123;
        host_write(2'd0, 32'h2214_3800 + 32'd2);
        n = 0;
        do begin @(posedge clk); #2; n++; end while (busy && n < 50);
        check("R5 edges to readback", n, 4);
        check("R3 field 5:3 set to 2", {24'b0, periph[8'h14]}, 32'hD5);
        host_read(2'd0, rd); check("R4 unity scale", rd, 32'd291);

        // R3 masks: zero, top bit with wide payload, full byte
        run_rmw("zero mask", 32'h2230_0007, 8'h5A, 12'h001);
        run_rmw("top bit", 32'h2231_80FF, 8'h00, 12'h7FF);
        run_rmw("full mask", 32'h2232_FF3C, 8'hAA, 12'h800);
        run_rmw("split mask", 32'h2233_6C05, 8'h93, 12'h0F0);

        // R4 negative scale and offset, R9 read-back of both
        host_write(2'd1, 32'h0000_FE80);
        host_write(2'd2, 32'hFFFF_FC18);
        host_read(2'd1, rd); check("R9 scale sign-extended", rd, 32'hFFFF_FE80);
        host_read(2'd2, rd); check("R9 offset", rd, 32'hFFFF_FC18);
        lat = 2;
        run_rmw("neg raw", 32'h2240_0F01, 8'h00, 12'hF00);
        check("R4 expected -616", m_result, 32'hFFFF_FD98);
        run_rmw("max raw", 32'h2241_0101, 8'h10, 12'h7FF);

        // R6 unknown opcode
        kind_log.delete();
        host_write(2'd0, 32'h2114_3802);
        repeat (6) @(negedge clk);
        check("R6 no transaction", kind_log.size(), 0);
        check("R6 err set", {31'b0, err}, 1);
        host_read(2'd3, rd); check("R6 R9 status err", rd, 32'h2);
        run_rmw("clears err", 32'h2242_0201, 8'h00, 12'h010);
        check("R6 err cleared", {31'b0, err}, 0);

        // R7 command during a run
        lat = 3;
        periph[8'h50] = 8'h00; periph[8'h51] = 8'h77;
        conv_val = 12'h020;
        kind_log.delete(); addr_log.delete();
        host_write(2'd0, 32'h2250_0101);
        repeat (3) @(negedge clk);
        host_write(2'd0, 32'h2251_FF55);
        #3 check("R7 err set", {31'b0, err}, 1);
        wait_idle();
        check("R7 run completes", {24'b0, periph[8'h50]}, 32'h01);
        check("R7 dropped cmd no write", {24'b0, periph[8'h51]}, 32'h77);
        check("R7 only one run", kind_log.size(), 3);
        host_read(2'd0, rd); check("R7 readback", rd, cond_ref(12'h020, 16'hFE80, 32'hFFFF_FC18));

        // R8 command in the finish cycle
        lat = 1;
        periph[8'h40] = 8'h0F; periph[8'h41] = 8'h00;
        conv_val = 12'h010;
        host_write(2'd0, 32'h2240_F00B);
        do @(posedge clk); while (!(xfer_req && xfer_ack && xfer_kind == 2'd2));
        host_write(2'd0, 32'h2241_0C03);
        conv_val = 12'h800;
        #3;
        check("R8 busy stays high", {31'b0, busy}, 1);
        check("R8 err clear", {31'b0, err}, 0);
        host_read(2'd0, rd); check("R8 first result", rd, 32'hFFFF_FC00);
        wait_idle();
        check("R8 first write-back", {24'b0, periph[8'h40]}, 32'hBF);
        check("R8 second write-back", {24'b0, periph[8'h41]}, 32'h0C);
        host_read(2'd0, rd); check("R8 second result", rd, 32'd2072);

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule